// File: doc/BRIEF.md
# Capture and Count-Source Input Unit

This block sits beside a free-running timer counter and observes four asynchronous capture pins. Each pin passes through a two-stage synchronizer and an edge detector running on the peripheral clock. A qualifying edge on a pin copies the present timer counter value into that pin's own 32-bit capture register. When enabled, the same edge also issues a one-cycle request to set the capture flag of that channel in the shared interrupt-flag register.

The block also produces the count-enable strobe for the timer counter. In timer mode the strobe is high on every clock. In the three counter modes it pulses once for each rising edge, each falling edge, or each edge of whichever capture pin the count-control register selects.

Software configures the unit and reads the captured values through a small register port. Address 0 holds capture control and address 1 holds count control. Addresses 4 to 7 read capture registers 0 to 3. Writes to the capture registers are ignored.

Top module: `capt_input_unit`

## Requirements
- R1: After reset, every readable register returns 0, `irqSet` is 0, and `countEn` is high because the count mode is timer mode.
- R2: When capture-control bit 3n is set, a rising edge on `capIn[n]` loads `timerCount` into capture register n. The new value is readable at address 4+n after the third rising clock edge that follows the pin change. The value stored is `timerCount` as sampled at that third edge.
- R3: When capture-control bit 3n+1 is set, a falling edge on `capIn[n]` loads capture register n with the same timing as R2.
- R4: When both bits 3n and 3n+1 are set, channel n captures on every transition. When neither bit is set, capture register n never changes.
- R5: When capture-control bit 3n+2 is set, each load of capture register n drives `irqSet[4+n]` high for exactly the cycle in which the new value first becomes readable. With the bit clear, or with no load, that bit stays low. `irqSet[3:0]` is always 0.
- R6: While count-control bits 1:0 equal 0 (timer mode), `countEn` is high on every cycle.
- R7: Count-control bits 1:0 equal to 1, 2 or 3 select counting on rising, falling or both edges. Each qualifying edge gives exactly one `countEn` high cycle, with the same latency as a capture. Two qualifying edges on consecutive clocks give two consecutive high cycles. Otherwise `countEn` is low.
- R8: Count-control bits 3:2 choose which capture pin (0 to 3) is the count source. Edges on the other pins produce no `countEn` pulse.
- R9: Address 0 reads capture control in bits 11:0. Address 1 reads count control in bits 3:0. Unused upper bits read 0, and addresses 2 and 3 read 0. A write to address 1 keeps only bits 3:0.
- R10: A capture on one channel leaves the other three capture registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| capIn | input | 4 | Asynchronous capture pins |
| timerCount | input | 32 | Current timer counter value |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | 12 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| countEn | output | 1 | Count-enable strobe for the timer counter |
| irqSet | output | 8 | Interrupt-flag set pulses; bit 4+n for capture channel n |

## Verification
Several properties are checked on every cycle. A capture register may change only when a load strobe preceded the change and an edge enable was set, and the new value must equal the counter value from that cycle. A flag pulse must trace back to a load with the interrupt enable set. In timer mode `countEn` must be high, and a counter-mode pulse must trace back to a count strobe. Only the bench scenarios can show the rest. These are the exact three-edge latency, polarity selection per channel, choice of count source, the back-to-back edge case, register readback masking, and the values restored by reset.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam int CAP_CH        = 4;
  localparam int CNT_W         = 32;
  localparam int SEL_W         = $clog2(CAP_CH);
  localparam int BITS_PER_CH   = 3;
  localparam int CAP_CTRL_W    = CAP_CH * BITS_PER_CH;
  localparam int CNT_CTRL_W    = 2 + SEL_W;
  localparam int IRQ_W         = 8;
  localparam int IRQ_CAP_BASE  = 4;
  localparam int ADDR_W        = 3;
  localparam int ADDR_CAP_CTRL = 0;
  localparam int ADDR_CNT_CTRL = 1;
  localparam int ADDR_CAP_BASE = 4;

  typedef enum logic [1:0] {
    CM_TIMER = 2'd0,
    CM_RISE  = 2'd1,
    CM_FALL  = 2'd2,
    CM_BOTH  = 2'd3
  } cnt_mode_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic [CAP_CH-1:0] loadCap;
    logic [CAP_CH-1:0] raiseIrq;
    logic              countPulse;
  } cap_strobe_t;
endpackage

// File: rtl/capt_edge_sync.sv
module capt_edge_sync #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pinAsync,
  output logic [NUM_CH-1:0] riseEv,
  output logic [NUM_CH-1:0] fallEv
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic meta, stable, last;
      always_ff @(posedge clk) begin
        if (!rstN) begin
          meta   <= 1'b0;
          stable <= 1'b0;
          last   <= 1'b0;
        end else begin
          meta   <= pinAsync[g];
          stable <= meta;
          last   <= stable;
        end
      end
      assign riseEv[g] = stable & ~last;
      assign fallEv[g] = ~stable & last;
    end
  endgenerate
endmodule

// File: rtl/capt_ctrl.sv
module capt_ctrl
  import capt_pkg::*;
#(
  parameter int NUM_CH = CAP_CH
) (
  input  logic [NUM_CH-1:0]  riseEv,
  input  logic [NUM_CH-1:0]  fallEv,
  input  logic [CAP_CTRL_W-1:0] capCtrl,
  input  logic [CNT_CTRL_W-1:0] cntCtrl,
  output cap_strobe_t        strobe
);
  localparam int RISE_OFS = 0;
  localparam int FALL_OFS = 1;
  localparam int IRQ_OFS  = 2;

  logic [NUM_CH-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cap
      assign hit[g] = (riseEv[g] & capCtrl[BITS_PER_CH*g + RISE_OFS])
                    | (fallEv[g] & capCtrl[BITS_PER_CH*g + FALL_OFS]);
      assign strobe.loadCap[g]  = hit[g];
      assign strobe.raiseIrq[g] = hit[g] & capCtrl[BITS_PER_CH*g + IRQ_OFS];
    end
  endgenerate

  cnt_mode_e        mode;
  logic [SEL_W-1:0] srcSel;
  logic             srcRise, srcFall;

  assign mode    = cnt_mode_e'(cntCtrl[1:0]);
  assign srcSel  = cntCtrl[2 +: SEL_W];
  assign srcRise = riseEv[srcSel];
  assign srcFall = fallEv[srcSel];

  always_comb begin
    unique case (mode)
      CM_RISE:  strobe.countPulse = srcRise;
      CM_FALL:  strobe.countPulse = srcFall;
      CM_BOTH:  strobe.countPulse = srcRise | srcFall;
      default:  strobe.countPulse = 1'b0;
    endcase
  end
endmodule

// File: rtl/capt_datapath.sv
module capt_datapath
  import capt_pkg::*;
#(
  parameter int NUM_CH = CAP_CH
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         regWrEn,
  input  logic [ADDR_W-1:0]            regAddr,
  input  logic [CAP_CTRL_W-1:0]        regWrData,
  input  logic [CNT_W-1:0]             timerCount,
  input  cap_strobe_t                  strobe,
  output logic [CAP_CTRL_W-1:0]        capCtrlQ,
  output logic [CNT_CTRL_W-1:0]        cntCtrlQ,
  output logic [NUM_CH-1:0][CNT_W-1:0] capValQ,
  output logic [CNT_W-1:0]             regRdData,
  output logic [IRQ_W-1:0]             irqSet,
  output logic                         countEn
);
  logic [NUM_CH-1:0] irqQ;
  logic              cntPulseQ;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capCtrlQ <= '0;
      cntCtrlQ <= '0;
    end else if (regWrEn) begin
      if (regAddr == ADDR_W'(ADDR_CAP_CTRL)) capCtrlQ <= regWrData;
      if (regAddr == ADDR_W'(ADDR_CNT_CTRL)) cntCtrlQ <= regWrData[CNT_CTRL_W-1:0];
    end
  end

  // per-channel snapshot registers
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_snap
      always_ff @(posedge clk) begin
        if (!rstN) capValQ[g] <= '0;
        else if (strobe.loadCap[g]) capValQ[g] <= timerCount;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ      <= '0;
      cntPulseQ <= 1'b0;
    end else begin
      irqQ      <= strobe.raiseIrq;
      cntPulseQ <= strobe.countPulse;
    end
  end

  always_comb begin
    irqSet = '0;
    irqSet[IRQ_CAP_BASE +: NUM_CH] = irqQ;
  end

  assign countEn = (cnt_mode_e'(cntCtrlQ[1:0]) == CM_TIMER) | cntPulseQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_CAP_CTRL)) regRdData[CAP_CTRL_W-1:0] = capCtrlQ;
    if (regAddr == ADDR_W'(ADDR_CNT_CTRL)) regRdData[CNT_CTRL_W-1:0] = cntCtrlQ;
    for (int c = 0; c < NUM_CH; c++) begin
      if (regAddr == ADDR_W'(ADDR_CAP_BASE + c)) regRdData = capValQ[c];
    end
  end
endmodule

// File: rtl/capt_input_unit.sv
module capt_input_unit
  import capt_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [CAP_CH-1:0]     capIn,
  input  logic [CNT_W-1:0]      timerCount,
  input  logic                  regWrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [CAP_CTRL_W-1:0] regWrData,
  output logic [CNT_W-1:0]      regRdData,
  output logic                  countEn,
  output logic [IRQ_W-1:0]      irqSet
);
  logic [CAP_CH-1:0]            riseEv, fallEv;
  logic [CAP_CTRL_W-1:0]        capCtrlQ;
  logic [CNT_CTRL_W-1:0]        cntCtrlQ;
  logic [CAP_CH-1:0][CNT_W-1:0] capValQ;
  cap_strobe_t                  strobe;

  capt_edge_sync #(.NUM_CH(CAP_CH)) u_sync (
    .clk(clk), .rstN(rstN), .pinAsync(capIn), .riseEv(riseEv), .fallEv(fallEv)
  );

  capt_ctrl #(.NUM_CH(CAP_CH)) u_ctrl (
    .riseEv(riseEv), .fallEv(fallEv), .capCtrl(capCtrlQ), .cntCtrl(cntCtrlQ),
    .strobe(strobe)
  );

  capt_datapath #(.NUM_CH(CAP_CH)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .timerCount(timerCount), .strobe(strobe),
    .capCtrlQ(capCtrlQ), .cntCtrlQ(cntCtrlQ), .capValQ(capValQ),
    .regRdData(regRdData), .irqSet(irqSet), .countEn(countEn)
  );
endmodule

// File: rtl/capt_input_unit_chk.sv
module capt_input_unit_chk
  import capt_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic [CNT_W-1:0]             timerCount,
  input logic [CAP_CTRL_W-1:0]        capCtrlQ,
  input logic [1:0]                   cntMode,
  input logic [CAP_CH-1:0][CNT_W-1:0] capValQ,
  input cap_strobe_t                  strobe,
  input logic [CAP_CH-1:0]            capIrq,
  input logic                         countEn
);
  genvar g;
  generate
    for (g = 0; g < CAP_CH; g++) begin : g_chk
      assert_load_value_R2: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(capValQ[g]) |-> (capValQ[g] == $past(timerCount)) && $past(strobe.loadCap[g]));

      assert_needs_edge_enable_R4: assert property (@(posedge clk) disable iff (!rstN)
        !$stable(capValQ[g]) |-> $past(capCtrlQ[3*g] || capCtrlQ[3*g+1]));

      assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rstN)
        capIrq[g] |-> $past(strobe.loadCap[g]) && $past(strobe.raiseIrq[g])
                      && $past(capCtrlQ[3*g+2]));
    end
  endgenerate

  assert_timer_mode_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode == 2'd0) |-> countEn);

  assert_count_source_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cntMode != 2'd0 && countEn) |-> $past(strobe.countPulse));
endmodule

bind capt_input_unit capt_input_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .timerCount(timerCount), .capCtrlQ(capCtrlQ),
  .cntMode(cntCtrlQ[1:0]), .capValQ(capValQ), .strobe(strobe),
  .capIrq(irqSet[capt_pkg::IRQ_CAP_BASE +: capt_pkg::CAP_CH]), .countEn(countEn)
);

// File: tb/capt_input_unit_tb.sv
module capt_input_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  capIn = 4'h0;
  logic [31:0] timerCount = 32'h0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [11:0] regWrData = 12'h0;
  logic [31:0] regRdData;
  logic        countEn;
  logic [7:0]  irqSet;

  int total = 0;
  int bad   = 0;
  logic [31:0] model [4];

  always #10 clk = ~clk;

  capt_input_unit u_dut (
    .clk(clk), .rstN(rstN), .capIn(capIn), .timerCount(timerCount),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .countEn(countEn), .irqSet(irqSet)
  );

  typedef struct packed {
    logic [11:0] capCtrl;
    logic [3:0]  cntCtrl;
    logic [1:0]  ch;
    logic        lvl;
    logic [31:0] tval;
    logic        expCap;
    logic        expIrq;
    logic        expCnt;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{12'h001, 4'h0, 2'd0, 1'b1, 32'h0000_0100, 1'b1, 1'b0, 1'b1}, // R2 rise ch0
    '{12'h001, 4'h0, 2'd0, 1'b0, 32'h0000_0200, 1'b0, 1'b0, 1'b1}, // R2 fall ignored
    '{12'h002, 4'h0, 2'd0, 1'b1, 32'h0000_0300, 1'b0, 1'b0, 1'b1}, // R3 rise ignored
    '{12'h002, 4'h0, 2'd0, 1'b0, 32'h0000_0400, 1'b1, 1'b0, 1'b1}, // R3 fall ch0
    '{12'h007, 4'h0, 2'd0, 1'b1, 32'h0000_0500, 1'b1, 1'b1, 1'b1}, // R4 R5 both
    '{12'h007, 4'h0, 2'd0, 1'b0, 32'h0000_0600, 1'b1, 1'b1, 1'b1}, // R4 both
    '{12'h000, 4'h0, 2'd0, 1'b1, 32'h0000_0700, 1'b0, 1'b0, 1'b1}, // R4 none
    '{12'h008, 4'h0, 2'd1, 1'b1, 32'h0000_0800, 1'b1, 1'b0, 1'b1}, // R2 ch1 no irq
    '{12'h028, 4'h0, 2'd1, 1'b0, 32'h0000_0900, 1'b0, 1'b0, 1'b1}, // R5 no load
    '{12'h028, 4'h0, 2'd1, 1'b1, 32'h0000_0A00, 1'b1, 1'b1, 1'b1}, // R5 ch1 irq
    '{12'hE00, 4'hD, 2'd3, 1'b1, 32'h0000_0B00, 1'b1, 1'b1, 1'b1}, // R7 rise mode
    '{12'hE00, 4'hD, 2'd3, 1'b0, 32'h0000_0C00, 1'b1, 1'b1, 1'b0}, // R7 fall no count
    '{12'hE00, 4'hE, 2'd3, 1'b1, 32'h0000_0C80, 1'b1, 1'b1, 1'b0}, // R7 fall mode
    '{12'hE00, 4'hE, 2'd3, 1'b0, 32'h0000_0CC0, 1'b1, 1'b1, 1'b1}, // R7 fall count
    '{12'h000, 4'hB, 2'd2, 1'b1, 32'h0000_0CE0, 1'b0, 1'b0, 1'b1}, // R7 R8 both
    '{12'h000, 4'hB, 2'd2, 1'b0, 32'h0000_0CF0, 1'b0, 1'b0, 1'b1}, // R7 both
    '{12'h000, 4'hB, 2'd3, 1'b1, 32'h0000_0CF8, 1'b0, 1'b0, 1'b0}, // R8 other pin
    '{12'h000, 4'hB, 2'd1, 1'b0, 32'h0000_0CFC, 1'b0, 1'b0, 1'b0}, // R8 other pin
    '{12'h0C0, 4'h0, 2'd2, 1'b1, 32'h0000_0D00, 1'b1, 1'b0, 1'b1}  // R2 ch2, R6
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [11:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic checkCaps(input string req);
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      readReg(3'(4 + c), v);
      check(v === model[c], req, v, model[c]);
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int c = 0; c < 4; c++) model[c] = 32'h0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      readReg(3'(a), v);
      check(v === 32'h0, "R1 reset read", v, 32'h0);
    end
    check(countEn === 1'b1, "R1 countEn after reset", 32'(countEn), 32'h1);
    check(irqSet === 8'h0, "R1 irqSet after reset", 32'(irqSet), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t t;
      logic [7:0] expIrq;
      logic expCe;
      t = VECS[i];
      writeReg(3'd0, t.capCtrl);
      writeReg(3'd1, {8'h0, t.cntCtrl});
      timerCount = t.tval;
      capIn[t.ch] = t.lvl;
      repeat (3) @(posedge clk);
      @(negedge clk);
      if (t.expCap) model[t.ch] = t.tval;
      checkCaps("R2/R3/R4/R10 capture value");
      expIrq = t.expIrq ? (8'h10 << t.ch) : 8'h0;
      check(irqSet === expIrq, "R5 irq pulse", 32'(irqSet), 32'(expIrq));
      expCe = (t.cntCtrl[1:0] == 2'd0) ? 1'b1 : t.expCnt;
      check(countEn === expCe, "R6/R7/R8 countEn at edge", 32'(countEn), 32'(expCe));
      @(negedge clk);
      check(irqSet === 8'h0, "R5 irq one cycle", 32'(irqSet), 32'h0);
      expCe = (t.cntCtrl[1:0] == 2'd0);
      check(countEn === expCe, "R7 countEn one cycle", 32'(countEn), 32'(expCe));
    end

    // R7: two qualifying edges on consecutive clocks, both-edge mode on pin 0
    writeReg(3'd0, 12'h000);
    writeReg(3'd1, 12'h003);
    capIn[0] = 1'b0;
    @(negedge clk);
    capIn[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(countEn === 1'b1, "R7 back-to-back first", 32'(countEn), 32'h1);
    @(negedge clk);
    check(countEn === 1'b1, "R7 back-to-back second", 32'(countEn), 32'h1);
    @(negedge clk);
    check(countEn === 1'b0, "R7 back-to-back end", 32'(countEn), 32'h0);
    checkCaps("R4 no capture with enables clear");

    // R9: readback masking
    writeReg(3'd0, 12'hFFF);
    writeReg(3'd1, 12'hFFF);
    readReg(3'd0, v);
    check(v === 32'h0000_0FFF, "R9 capture control read", v, 32'hFFF);
    readReg(3'd1, v);
    check(v === 32'h0000_000F, "R9 count control read", v, 32'hF);
    readReg(3'd2, v);
    check(v === 32'h0, "R9 address 2 read", v, 32'h0);
    readReg(3'd3, v);
    check(v === 32'h0, "R9 address 3 read", v, 32'h0);
    writeReg(3'd5, 12'hABC);
    checkCaps("R9 capture register not writable");

    // R1: reset mid-run clears captured values and configuration
    writeReg(3'd1, 12'h000);
    capIn = 4'h0;
    repeat (5) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) model[c] = 32'h0;
    checkCaps("R1 capture cleared by reset");
    readReg(3'd0, v);
    check(v === 32'h0, "R1 capture control cleared", v, 32'h0);
    check(countEn === 1'b1, "R1 R6 timer mode after reset", 32'(countEn), 32'h1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule